// File: doc/BRIEF.md
# Micro-op Issue Bandwidth Controller

This block keeps the issue budget of an in-order superscalar front end. Each cycle the budget starts at `ISSUE_WIDTH` micro-ops and the issued count starts at zero. Up to `LANES` candidate instructions arrive in program order. Each candidate carries a micro-op count, a flag that makes it open a new issue group and a flag that makes it close its group. Candidates are accepted strictly in order: the first candidate that is not accepted blocks every later lane for that cycle.

An instruction with more micro-ops than the budget still left may issue. Its surplus micro-ops become a carry-over, which uses up the budget of the following cycles before any new instruction can go. An external hazard on a candidate, or a stall held from outside, ends issue for the rest of the cycle and forces the budget to zero. The outputs are combinational views of the current cycle: the accept vector, the budget left after the last lane, the issued count, and a flag that shows a carry-over entered the cycle.

Top module: `ibw_ctrl`

## Requirements
- R1: At the start of every cycle with no pending carry-over and no held stall, the budget is `ISSUE_WIDTH` and the issued count is 0. With no valid candidate, `budget_left` = `ISSUE_WIDTH` and `issued_cnt` = 0.
- R2: No candidate is accepted while `stall_hold` is high, and `budget_left` is then 0. No candidate is accepted in a cycle whose incoming carry-over is still larger than `ISSUE_WIDTH`.
- R3: A candidate whose micro-op count exceeds `ISSUE_WIDTH` passes the budget test whatever budget is left.
- R4: Any other candidate needs a remaining budget at least equal to its micro-op count. When it issues within budget, its count is added to `issued_cnt` and subtracted from the budget.
- R5: A candidate with `cand_begin` set is accepted only while `issued_cnt` of the cycle so far is 0.
- R6: An accepted candidate whose count exceeds the remaining budget records a carry-over of count minus budget, sets the budget to 0, leaves the issued count unchanged and blocks the later lanes. `carry_busy` is 1 in the next cycle.
- R7: An accepted candidate with `cand_end` set that fits its budget sets the budget to 0.
- R8: In a following cycle where the carry-over exceeds `ISSUE_WIDTH`, the carry-over drops by `ISSUE_WIDTH` and the budget is 0.
- R9: When the carry-over is at most `ISSUE_WIDTH`, it completes in that cycle and the budget becomes `ISSUE_WIDTH` minus the carry-over, or 0 if the carried instruction had `cand_end` set. New candidates may then use what is left in that same cycle.
- R10: An accepted-eligible candidate with `cand_hazard` set is not accepted. It forces the budget to 0 and blocks all later lanes.
- R11: `issued_cnt` never exceeds `ISSUE_WIDTH`, and `budget_left` + `issued_cnt` never exceeds `ISSUE_WIDTH`.
- R12: Acceptance is in program order. A lane that is invalid or refused blocks every higher lane, so `issue_accept` is always a contiguous run starting at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | LANES | Candidate present, lane 0 oldest |
| cand_uops | input | LANES*UOP_W | Micro-op count per lane, lane i at bits [i*UOP_W +: UOP_W] |
| cand_begin | input | LANES | Candidate must open an issue group |
| cand_end | input | LANES | Candidate closes its issue group |
| cand_hazard | input | LANES | Candidate has a hazard this cycle |
| stall_hold | input | 1 | A stall is held this cycle |
| issue_accept | output | LANES | Candidate accepted this cycle |
| budget_left | output | $clog2(ISSUE_WIDTH+1) | Budget left after the last lane |
| issued_cnt | output | $clog2(ISSUE_WIDTH+1) | Micro-ops issued within budget this cycle |
| carry_busy | output | 1 | A carry-over entered this cycle |

## Verification
A wrong carry-over remainder or a lost group-closing flag never shows up in the cycle of the spill. It shows up one or more cycles later, as a wrong `budget_left`, a candidate accepted or refused against its reference, or `carry_busy` staying high one cycle too long or too short. The reference model is compared on every cycle, so such a fault is reported in the first cycle where the carry settles, at most ceil(carry/ISSUE_WIDTH) cycles after the spill. A fault in the lane chain shows up in the same cycle as a non-contiguous or miscounted accept vector.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
  typedef enum logic [2:0] {
    LO_IDLE   = 3'd0,
    LO_REFUSE = 3'd1,
    LO_ISSUE  = 3'd2,
    LO_SPILL  = 3'd3,
    LO_STALL  = 3'd4
  } lane_outcome_e;
endpackage

// File: rtl/ibw_carry.sv
module ibw_carry #(
  parameter int ISSUE_WIDTH = 4,
  parameter int UOP_W       = 3,
  localparam int BW = $clog2(ISSUE_WIDTH + 1),
  localparam int DW = (UOP_W > BW ? UOP_W : BW) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spill_i,
  input  logic [UOP_W-1:0] spill_amt_i,
  input  logic             spill_end_i,
  output logic             busy_o,
  output logic             still_o,
  output logic [BW-1:0]    budget_o
);
  localparam logic [DW-1:0] WIDTH_D = DW'(ISSUE_WIDTH);

  logic             pend_q, pend_d;
  logic [UOP_W-1:0] left_q, left_d;
  logic             end_q, end_d;
  logic             en;
  logic [DW-1:0]    left_ext;

  assign left_ext = DW'(left_q);
  assign busy_o   = pend_q;
  assign still_o  = pend_q && (left_ext > WIDTH_D);

  // settle the carry first, before any lane sees the budget
  always_comb begin
    if (!pend_q)
      budget_o = BW'(ISSUE_WIDTH);
    else if (still_o || end_q)
      budget_o = '0;
    else
      budget_o = BW'(WIDTH_D - left_ext);
  end

  assign en = pend_q | spill_i;

  always_comb begin
    pend_d = pend_q;
    left_d = left_q;
    end_d  = end_q;
    if (still_o) begin
      left_d = UOP_W'(left_ext - WIDTH_D);
    end else if (pend_q) begin
      pend_d = 1'b0;
      left_d = '0;
    end
    if (spill_i) begin
      pend_d = 1'b1;
      left_d = spill_amt_i;
      end_d  = spill_end_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      left_q <= '0;
      end_q  <= 1'b0;
    end else if (en) begin
      pend_q <= pend_d;
      left_q <= left_d;
      end_q  <= end_d;
    end
  end

  // a new spill only when the carry of this cycle has fully drained
  p_spill_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spill_i |-> !still_o);
  // a carry above the width drains by exactly one width per cycle
  p_drain_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    still_o |=> (pend_q && (DW'(left_q) == $past(left_ext) - WIDTH_D)));
  // a carry that fits the width completes in that cycle
  p_complete_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !still_o && !spill_i) |=> !pend_q);
endmodule

// File: rtl/ibw_lane.sv
module ibw_lane
  import ibw_pkg::*;
#(
  parameter int ISSUE_WIDTH = 4,
  parameter int UOP_W       = 3,
  localparam int BW = $clog2(ISSUE_WIDTH + 1),
  localparam int DW = (UOP_W > BW ? UOP_W : BW) + 1
) (
  input  logic             open_i,
  input  logic [BW-1:0]    budget_i,
  input  logic [BW-1:0]    issued_i,
  input  logic             valid_i,
  input  logic [UOP_W-1:0] uops_i,
  input  logic             begin_i,
  input  logic             end_i,
  input  logic             hazard_i,
  output logic             open_o,
  output logic [BW-1:0]    budget_o,
  output logic [BW-1:0]    issued_o,
  output logic             accept_o,
  output lane_outcome_e    outcome_o,
  output logic [UOP_W-1:0] spill_amt_o
);
  localparam logic [DW-1:0] WIDTH_D = DW'(ISSUE_WIDTH);

  logic [DW-1:0] u_ext, b_ext;
  logic          wide, fits, grp_ok;

  assign u_ext  = DW'(uops_i);
  assign b_ext  = DW'(budget_i);
  assign wide   = u_ext > WIDTH_D;
  assign fits   = wide || (b_ext >= u_ext);
  assign grp_ok = !begin_i || (issued_i == '0);

  always_comb begin
    open_o      = 1'b0;
    budget_o    = budget_i;
    issued_o    = issued_i;
    spill_amt_o = '0;
    outcome_o   = LO_IDLE;
    if (open_i && valid_i) begin
      if (!(fits && grp_ok)) begin
        outcome_o = LO_REFUSE;
      end else if (hazard_i) begin
        outcome_o = LO_STALL;
        budget_o  = '0;
      end else if (u_ext > b_ext) begin
        outcome_o   = LO_SPILL;
        spill_amt_o = UOP_W'(u_ext - b_ext);
        budget_o    = '0;
      end else begin
        outcome_o = LO_ISSUE;
        open_o    = 1'b1;
        issued_o  = BW'(DW'(issued_i) + u_ext);
        budget_o  = end_i ? '0 : BW'(b_ext - u_ext);
      end
    end
  end

  assign accept_o = (outcome_o == LO_ISSUE) || (outcome_o == LO_SPILL);
endmodule

// File: rtl/ibw_ctrl.sv
module ibw_ctrl
  import ibw_pkg::*;
#(
  parameter int ISSUE_WIDTH = 4,
  parameter int LANES       = 4,
  parameter int UOP_W       = 3,
  localparam int BW = $clog2(ISSUE_WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       cand_valid,
  input  logic [LANES*UOP_W-1:0] cand_uops,
  input  logic [LANES-1:0]       cand_begin,
  input  logic [LANES-1:0]       cand_end,
  input  logic [LANES-1:0]       cand_hazard,
  input  logic                   stall_hold,
  output logic [LANES-1:0]       issue_accept,
  output logic [BW-1:0]          budget_left,
  output logic [BW-1:0]          issued_cnt,
  output logic                   carry_busy
);
  logic             open_c   [LANES+1];
  logic [BW-1:0]    budget_c [LANES+1];
  logic [BW-1:0]    issued_c [LANES+1];
  lane_outcome_e    outcome  [LANES];
  logic [UOP_W-1:0] amt      [LANES];
  logic             still;
  logic [BW-1:0]    carry_budget;
  logic             spill;
  logic [UOP_W-1:0] spill_amt;
  logic             spill_end;

  ibw_carry #(.ISSUE_WIDTH(ISSUE_WIDTH), .UOP_W(UOP_W)) u_carry (
    .clk        (clk),
    .rst_n      (rst_n),
    .spill_i    (spill),
    .spill_amt_i(spill_amt),
    .spill_end_i(spill_end),
    .busy_o     (carry_busy),
    .still_o    (still),
    .budget_o   (carry_budget)
  );

  assign open_c[0]   = !still && !stall_hold;
  assign budget_c[0] = stall_hold ? '0 : carry_budget;
  assign issued_c[0] = '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ibw_lane #(.ISSUE_WIDTH(ISSUE_WIDTH), .UOP_W(UOP_W)) u_lane (
      .open_i     (open_c[i]),
      .budget_i   (budget_c[i]),
      .issued_i   (issued_c[i]),
      .valid_i    (cand_valid[i]),
      .uops_i     (cand_uops[i*UOP_W +: UOP_W]),
      .begin_i    (cand_begin[i]),
      .end_i      (cand_end[i]),
      .hazard_i   (cand_hazard[i]),
      .open_o     (open_c[i+1]),
      .budget_o   (budget_c[i+1]),
      .issued_o   (issued_c[i+1]),
      .accept_o   (issue_accept[i]),
      .outcome_o  (outcome[i]),
      .spill_amt_o(amt[i])
    );

    // a group opener issues only into an empty cycle
    p_begin_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_accept[i] && cand_begin[i]) |-> (issued_c[i] == '0));
  end

  // at most one lane can spill because a spill closes the chain
  always_comb begin
    spill     = 1'b0;
    spill_amt = '0;
    spill_end = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (outcome[i] == LO_SPILL) begin
        spill     = 1'b1;
        spill_amt = spill_amt | amt[i];
        spill_end = spill_end | cand_end[i];
      end
    end
  end

  assign budget_left = budget_c[LANES];
  assign issued_cnt  = issued_c[LANES];

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(issued_cnt) <= ISSUE_WIDTH) &&
    (int'(budget_left) + int'(issued_cnt) <= ISSUE_WIDTH));
  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hold |-> (issue_accept == '0 && budget_left == '0));
  p_in_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_accept & (issue_accept + 1'b1)) == '0));
  p_spill_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spill |=> carry_busy);
endmodule

// File: tb/sim_ibw_ctrl.sv
module sim_ibw_ctrl;
  localparam int W  = 4;
  localparam int L  = 4;
  localparam int UW = 3;
  localparam int BW = $clog2(W + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [L-1:0]    cand_valid = '0;
  logic [L*UW-1:0] cand_uops = '0;
  logic [L-1:0]    cand_begin = '0;
  logic [L-1:0]    cand_end = '0;
  logic [L-1:0]    cand_hazard = '0;
  logic            stall_hold = 1'b0;
  logic [L-1:0]    issue_accept;
  logic [BW-1:0]   budget_left;
  logic [BW-1:0]   issued_cnt;
  logic            carry_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  int m_pend = 0;
  int m_left = 0;
  int m_end  = 0;

  always #2 clk = ~clk;

  ibw_ctrl #(.ISSUE_WIDTH(W), .LANES(L), .UOP_W(UW)) u0 (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_uops(cand_uops),
    .cand_begin(cand_begin), .cand_end(cand_end), .cand_hazard(cand_hazard),
    .stall_hold(stall_hold), .issue_accept(issue_accept),
    .budget_left(budget_left), .issued_cnt(issued_cnt), .carry_busy(carry_busy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, then advance the model for the edge
  task automatic step(input logic [L-1:0] v, input int u0v, input int u1v,
                      input int u2v, input int u3v, input logic [L-1:0] bg,
                      input logic [L-1:0] en, input logic [L-1:0] hz,
                      input logic hold, input string tag);
    int us[L];
    int bud, iss, open, acc, busy, np, nl, ne;
    us[0] = u0v; us[1] = u1v; us[2] = u2v; us[3] = u3v;
    @(negedge clk);
    cand_valid = v; cand_begin = bg; cand_end = en; cand_hazard = hz; stall_hold = hold;
    for (int i = 0; i < L; i++) cand_uops[i*UW +: UW] = UW'(us[i]);
    busy = m_pend;
    bud = W; iss = 0; acc = 0; np = m_pend; nl = m_left; ne = m_end;
    if (m_pend != 0) begin
      if (m_left > W) begin
        nl = m_left - W; bud = 0;
      end else begin
        bud = (m_end != 0) ? 0 : W - m_left; np = 0;
      end
    end
    open = (np == 0 && !hold) ? 1 : 0;
    if (hold) bud = 0;
    for (int i = 0; i < L; i++) begin
      if (open == 0) break;
      if (!v[i]) begin open = 0; break; end
      if (!((us[i] > W || bud >= us[i]) && (!bg[i] || iss == 0))) begin open = 0; break; end
      if (hz[i]) begin bud = 0; open = 0; break; end
      acc |= (1 << i);
      if (us[i] > bud) begin
        np = 1; nl = us[i] - bud; ne = en[i]; bud = 0; open = 0;
      end else begin
        iss += us[i];
        bud = en[i] ? 0 : bud - us[i];
      end
    end
    #1;
    chk(tag, "issue_accept", int'(issue_accept), acc);
    chk(tag, "budget_left", int'(budget_left), bud);
    chk(tag, "issued_cnt", int'(issued_cnt), iss);
    chk(tag, "carry_busy", int'(carry_busy), busy);
    m_pend = np; m_left = (np != 0) ? nl : 0; m_end = ne;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1'b1;
    // R1: idle reload
    step(4'b0000, 0,0,0,0, 4'b0, 4'b0, 4'b0, 0, "R1");
    // R4: fits use up the budget, third lane refused for lack of budget
    step(4'b0111, 2,2,1,0, 4'b0, 4'b0, 4'b0, 0, "R4");
    step(4'b0111, 1,2,2,0, 4'b0, 4'b0, 4'b0, 0, "R4 R12");
    // R3 R6: wide candidate spills 6-1=5
    step(4'b0111, 3,6,1,0, 4'b0, 4'b0, 4'b0, 0, "R3 R6");
    // R8 R2: carry 5>4 drains to 1, new candidates refused
    step(4'b0001, 1,0,0,0, 4'b0, 4'b0, 4'b0, 0, "R8 R2");
    // R9: carry 1 completes, budget 3 for new candidates
    step(4'b0011, 2,1,0,0, 4'b0, 4'b0, 4'b0, 0, "R9");
    // R3: wide spill at budget 0 after an end-group issue, then R9 end-group completion
    step(4'b0011, 1,5,0,0, 4'b0, 4'b0011, 4'b0, 0, "R7 R3");
    step(4'b0001, 1,0,0,0, 4'b0, 4'b0, 4'b0, 0, "R8");
    step(4'b0001, 1,0,0,0, 4'b0, 4'b0, 4'b0, 0, "R9");
    // R5: begin-group in lane 1 refused, in lane 0 accepted
    step(4'b0011, 1,1,0,0, 4'b0010, 4'b0, 4'b0, 0, "R5");
    step(4'b0011, 1,1,0,0, 4'b0001, 4'b0, 4'b0, 0, "R5");
    // R7: end-group closes the cycle
    step(4'b0011, 1,1,0,0, 4'b0, 4'b0001, 4'b0, 0, "R7");
    // R10: hazard in lane 1 zeroes the budget
    step(4'b0111, 1,1,1,0, 4'b0, 4'b0, 4'b0010, 0, "R10");
    // R2: held stall
    step(4'b1111, 1,1,1,1, 4'b0, 4'b0, 4'b0, 1, "R2");
    // R12: invalid lane 1 blocks lane 2
    step(4'b0101, 1,1,1,0, 4'b0, 4'b0, 4'b0, 0, "R12");
    // R11 R12: mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [L-1:0] v, bg, en, hz;
      int a, b, c, d;
      v  = 4'($urandom_range(0, 15)) | 4'b0001;
      bg = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      en = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      hz = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 15)) : 4'b0;
      a = $urandom_range(1, 7); b = $urandom_range(1, 4);
      c = $urandom_range(1, 7); d = $urandom_range(1, 3);
      step(v, a, b, c, d, bg, en, hz, ($urandom_range(0, 19) == 0), "R11 R12");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule